// File: doc/BRIEF.md
# Interleaved System Address Decoder

This block turns a physical system address into a socket number, a memory controller number and a channel number. Each node keeps a table of 24 programmable address ranges. The block walks the table of the starting node and finds the range that holds the address. It takes an interleave index from selected address bits and reads a 4-bit target from the matched range's interleave word. A target may point at another node. In that case the block moves to that node's table and scans again, which it does at most once. A local target gives a logical channel, either directly or through a modulo-3 / modulo-2 computation on shifted address bits. The logical channel then picks the controller and channel fields out of a packed route word.

All configuration goes in through one write port. The port loads range entries, interleave words, a route word and a source id for each node, plus the global low and high memory limits. A request starts with a one-cycle `start` pulse. The block examines one table entry per clock. It answers with a one-cycle `done` pulse, which carries either the decoded fields or an error flag. Every lookup begins at node 0.

Top module: `ilv_addr_decoder`

## Requirements
- R1: An address at or above the high limit is rejected, and so is an address at or above the low limit but below 4 GiB. The rejection shows as `done` with `err`, seen right after the edge that accepts `start`.
- R2: A range word (`cfg_kind` 0) uses bit 0 as enable and bits 2:1 as interleave mode. Bits 6:5 select the modulo-2 variant, bit 27 enables modulo-3 and bits 31:30 give the modulo-3 shift. Bits 26:7 are the upper limit. The range ends at that field shifted left by 26, with the 26 low bits set to one.
- R3: Entries are scanned from index 0. Each entry's lower bound is the previous entry's end plus one, starting from 0, and a disabled entry still moves this bound. The first enabled entry that holds the address wins. If no entry matches, the result is an error.
- R4: The interleave index is address bits [8:6], [10:8], [14:12] or [32:30] for interleave modes 0, 1, 2 and 3.
- R5: The target is the nibble at bit 4×index of the matched entry's interleave word (`cfg_kind` 1). When target bit 3 is set, the target is local.
- R6: When target bit 3 is clear, bits 2:0 name a source id. The scan restarts at index 0 in the lowest-numbered node with that source id (`cfg_kind` 3). A second remote target is an error, and so is a source id that no node holds.
- R7: With modulo-3 disabled, the logical channel is target bits 2:0.
- R8: With modulo-3 enabled, the shift is 6, 8 or 12 for shift modes 0, 1 and 2. Shift mode 3 is an error. Let s = address >> shift. The base is s mod 3 for select 0, s mod 2 for select 1, {v, not v} for select 2 and {v, 0} for select 3, where v = s mod 2. The logical channel is {base, target bit 0}.
- R9: The controller is route word (`cfg_kind` 2) bits [3·lch+2 : 3·lch], and the channel is route bits [2·lch+19 : 2·lch+18]. The socket is the source id of the node where the scan ended.
- R10: The block examines one entry per cycle. A request that examines E entries in total, across both passes, raises `done` E cycles after the accepting edge. `done` lasts one cycle, and `err` is high only while `done` is high.
- R11: A `start` that arrives while a lookup is in progress is ignored. The result belongs to the request that was accepted.
- R12: After reset, `done`, `err`, `socket`, `mc` and `chan` are 0. A write with `cfg_kind` 4 sets the low limit and `cfg_kind` 5 sets the high limit. A write replaces the old value and affects later lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 3 | What to write: 0 range, 1 interleave, 2 route, 3 source id, 4 low limit, 5 high limit |
| cfg_node | input | $clog2(NODES) | Node addressed by the write |
| cfg_idx | input | $clog2(ENTRIES) | Table index for range and interleave writes |
| cfg_data | input | AW | Write data |
| start | input | 1 | Request pulse |
| req_addr | input | AW | System address to decode |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Decode failed (only with done) |
| socket | output | 3 | Source id of the resolving node |
| mc | output | 3 | Memory controller |
| chan | output | 2 | Channel |

## Verification
The bench builds the block with NODES = 4, AW = 40 and 24 entries per table. With four nodes, some remote targets match a node and others match none, and one remote target points back at node 0 itself, which forces the second-remote error. The 40-bit address covers the interleave mode 3 index bits, the hole below 4 GiB and the high limit. Sweeping the address bits under every range lets the bench reach every interleave index, every modulo-3 shift and select, and every route field position.

// File: rtl/ilv_dec_pkg.sv
package ilv_dec_pkg;

    localparam int LIM_LSB  = 26;
    localparam int SRC_W    = 3;
    localparam int ROUTE_W  = 34;
    localparam int MC_W     = 3;
    localparam int CH_W     = 2;
    localparam int CH_BASE  = 18;
    localparam int ILV_W    = 32;

    typedef enum logic [2:0] {
        CK_RANGE = 3'd0,
        CK_ILV   = 3'd1,
        CK_ROUTE = 3'd2,
        CK_SRC   = 3'd3,
        CK_LOW   = 3'd4,
        CK_HIGH  = 3'd5
    } cfg_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } dec_state_e;

    typedef struct packed {
        logic [1:0]  m3_shift;
        logic        m3_en;
        logic [19:0] limit;
        logic [1:0]  m2_sel;
        logic [1:0]  ilv_mode;
        logic        en;
    } range_ent_t;

    function automatic logic [3:0] m3_shift_amt(input logic [1:0] mode);
        case (mode)
            2'd0:    return 4'd6;
            2'd1:    return 4'd8;
            default: return 4'd12;
        endcase
    endfunction

endpackage

// File: rtl/ilv_cfg_store.sv
module ilv_cfg_store
    import ilv_dec_pkg::*;
#(
    parameter int NODES   = 8,
    parameter int ENTRIES = 24,
    parameter int AW      = 46,
    parameter int NW      = 3,
    parameter int EW      = 5
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [2:0]             kind,
    input  logic [NW-1:0]          wnode,
    input  logic [EW-1:0]          widx,
    input  logic [AW-1:0]          wdata,
    input  logic [NW-1:0]          rd_node,
    input  logic [EW-1:0]          rd_idx,
    output range_ent_t             rd_ent,
    output logic [ILV_W-1:0]       rd_ilv,
    output logic [ROUTE_W-1:0]     rd_route,
    output logic [SRC_W-1:0]       rd_src,
    output logic [NODES*SRC_W-1:0] src_all,
    output logic [AW-1:0]          lo_lim,
    output logic [AW-1:0]          hi_lim
);
    localparam int SLOTS = NODES * ENTRIES;
    localparam int SAW   = $clog2(SLOTS);

    range_ent_t         ent_mem   [SLOTS];
    logic [ILV_W-1:0]   ilv_mem   [SLOTS];
    logic [ROUTE_W-1:0] route_mem [NODES];
    logic [SRC_W-1:0]   src_mem   [NODES];

    logic [SAW-1:0] wa, ra;

    assign wa = SAW'(wnode) * SAW'(ENTRIES) + SAW'(widx);
    assign ra = SAW'(rd_node) * SAW'(ENTRIES) + SAW'(rd_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) begin
                ent_mem[i] <= '0;
                ilv_mem[i] <= '0;
            end
            for (int n = 0; n < NODES; n++) begin
                route_mem[n] <= '0;
                src_mem[n]   <= '0;
            end
            lo_lim <= '0;
            hi_lim <= '0;
        end else if (we) begin
            case (cfg_kind_e'(kind))
                CK_RANGE: begin
                    ent_mem[wa].en       <= wdata[0];
                    ent_mem[wa].ilv_mode <= wdata[2:1];
                    ent_mem[wa].m2_sel   <= wdata[6:5];
                    ent_mem[wa].limit    <= wdata[26:7];
                    ent_mem[wa].m3_en    <= wdata[27];
                    ent_mem[wa].m3_shift <= wdata[31:30];
                end
                CK_ILV:   ilv_mem[wa]      <= wdata[ILV_W-1:0];
                CK_ROUTE: route_mem[wnode] <= wdata[ROUTE_W-1:0];
                CK_SRC:   src_mem[wnode]   <= wdata[SRC_W-1:0];
                CK_LOW:   lo_lim           <= wdata;
                CK_HIGH:  hi_lim           <= wdata;
                default:  ;
            endcase
        end
    end

    assign rd_ent   = ent_mem[ra];
    assign rd_ilv   = ilv_mem[ra];
    assign rd_route = route_mem[rd_node];
    assign rd_src   = src_mem[rd_node];

    for (genvar g = 0; g < NODES; g++) begin : g_src
        assign src_all[g*SRC_W +: SRC_W] = src_mem[g];
    end

endmodule

// File: rtl/ilv_target_resolve.sv
module ilv_target_resolve
    import ilv_dec_pkg::*;
#(
    parameter int AW = 46
) (
    input  logic [AW-1:0]      addr,
    input  logic [1:0]         ilv_mode,
    input  logic               m3_en,
    input  logic [1:0]         m3_shift,
    input  logic [1:0]         m2_sel,
    input  logic [ILV_W-1:0]   ilv_word,
    input  logic [ROUTE_W-1:0] route,
    output logic               remote,
    output logic [SRC_W-1:0]   tgt_node,
    output logic               illegal,
    output logic [MC_W-1:0]    mc,
    output logic [CH_W-1:0]    ch
);
    logic [2:0]    idx;
    logic [3:0]    tgt;
    logic [AW-1:0] s;
    logic [1:0]    r3;
    logic [1:0]    base;
    logic [2:0]    lch;

    always_comb begin
        case (ilv_mode)
            2'd0:    idx = addr[8:6];
            2'd1:    idx = addr[10:8];
            2'd2:    idx = addr[14:12];
            default: idx = addr[32:30];
        endcase
        tgt      = ilv_word[idx*4 +: 4];
        remote   = ~tgt[3];
        tgt_node = tgt[2:0];

        s  = addr >> m3_shift_amt(m3_shift);
        r3 = 2'(s % AW'(3));
        case (m2_sel)
            2'd0:    base = r3;
            2'd1:    base = {1'b0, s[0]};
            2'd2:    base = {s[0], ~s[0]};
            default: base = {s[0], 1'b0};
        endcase
        lch     = m3_en ? {base, tgt[0]} : tgt[2:0];
        illegal = m3_en && (m3_shift == 2'd3);

        mc = route[MC_W*lch +: MC_W];
        ch = route[CH_BASE + CH_W*lch +: CH_W];
    end

endmodule

// File: rtl/ilv_node_find.sv
module ilv_node_find
    import ilv_dec_pkg::*;
#(
    parameter int NODES = 8,
    parameter int NW    = 3
) (
    input  logic [NODES*SRC_W-1:0] src_all,
    input  logic [SRC_W-1:0]       want,
    output logic                   found,
    output logic [NW-1:0]          node
);
    logic [NODES-1:0] hits;

    for (genvar g = 0; g < NODES; g++) begin : g_cmp
        assign hits[g] = (src_all[g*SRC_W +: SRC_W] == want);
    end

    always_comb begin
        found = |hits;
        node  = '0;
        for (int n = NODES - 1; n >= 0; n--) begin
            if (hits[n]) node = NW'(n);
        end
    end

endmodule

// File: rtl/ilv_addr_decoder.sv
module ilv_addr_decoder
    import ilv_dec_pkg::*;
#(
    parameter int NODES   = 8,
    parameter int ENTRIES = 24,
    parameter int AW      = 46,
    localparam int NW     = (NODES > 1) ? $clog2(NODES) : 1,
    localparam int EW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_kind,
    input  logic [NW-1:0]     cfg_node,
    input  logic [EW-1:0]     cfg_idx,
    input  logic [AW-1:0]     cfg_data,
    input  logic              start,
    input  logic [AW-1:0]     req_addr,
    output logic              done,
    output logic              err,
    output logic [SRC_W-1:0]  socket,
    output logic [MC_W-1:0]   mc,
    output logic [CH_W-1:0]   chan
);
    localparam logic [AW:0] FOUR_G = (AW+1)'(1) << 32;

    dec_state_e         state;
    logic               busy;
    logic [AW-1:0]      addr_q;
    logic [NW-1:0]      node_q;
    logic [EW-1:0]      idx_q;
    logic [AW:0]        prev_q;
    logic               redir_q;

    range_ent_t         cur_ent;
    logic [ILV_W-1:0]   cur_ilv;
    logic [ROUTE_W-1:0] cur_route;
    logic [SRC_W-1:0]   cur_src;
    logic [NODES*SRC_W-1:0] src_all;
    logic [AW-1:0]      lo_lim, hi_lim;

    logic               remote, illegal, found;
    logic [SRC_W-1:0]   tgt_node;
    logic [NW-1:0]      found_node;
    logic [MC_W-1:0]    mc_d;
    logic [CH_W-1:0]    ch_d;
    logic [AW-1:0]      lim;
    logic               hit, oor;

    ilv_cfg_store #(
        .NODES(NODES), .ENTRIES(ENTRIES), .AW(AW), .NW(NW), .EW(EW)
    ) u_store (
        .clk(clk), .rst(rst), .we(cfg_we), .kind(cfg_kind),
        .wnode(cfg_node), .widx(cfg_idx), .wdata(cfg_data),
        .rd_node(node_q), .rd_idx(idx_q),
        .rd_ent(cur_ent), .rd_ilv(cur_ilv), .rd_route(cur_route),
        .rd_src(cur_src), .src_all(src_all),
        .lo_lim(lo_lim), .hi_lim(hi_lim)
    );

    ilv_target_resolve #(.AW(AW)) u_res (
        .addr(addr_q), .ilv_mode(cur_ent.ilv_mode), .m3_en(cur_ent.m3_en),
        .m3_shift(cur_ent.m3_shift), .m2_sel(cur_ent.m2_sel),
        .ilv_word(cur_ilv), .route(cur_route),
        .remote(remote), .tgt_node(tgt_node), .illegal(illegal),
        .mc(mc_d), .ch(ch_d)
    );

    ilv_node_find #(.NODES(NODES), .NW(NW)) u_find (
        .src_all(src_all), .want(tgt_node), .found(found), .node(found_node)
    );

    assign busy = (state == ST_SCAN);
    assign lim  = AW'({cur_ent.limit, {LIM_LSB{1'b1}}});
    assign hit  = cur_ent.en && ({1'b0, addr_q} >= prev_q) && (addr_q <= lim);
    assign oor  = (req_addr >= hi_lim) ||
                  ((req_addr >= lo_lim) && ({1'b0, req_addr} < FOUR_G));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            done    <= 1'b0;
            err     <= 1'b0;
            socket  <= '0;
            mc      <= '0;
            chan    <= '0;
            addr_q  <= '0;
            node_q  <= '0;
            idx_q   <= '0;
            prev_q  <= '0;
            redir_q <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        addr_q  <= req_addr;
                        node_q  <= '0;
                        idx_q   <= '0;
                        prev_q  <= '0;
                        redir_q <= 1'b0;
                        if (oor) begin
                            done <= 1'b1;
                            err  <= 1'b1;
                        end else begin
                            state <= ST_SCAN;
                        end
                    end
                end
                default: begin
                    if (hit) begin
                        if (remote) begin
                            if (redir_q || !found) begin
                                done  <= 1'b1;
                                err   <= 1'b1;
                                state <= ST_IDLE;
                            end else begin
                                node_q  <= found_node;
                                redir_q <= 1'b1;
                                idx_q   <= '0;
                                prev_q  <= '0;
                            end
                        end else if (illegal) begin
                            done  <= 1'b1;
                            err   <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            done   <= 1'b1;
                            socket <= cur_src;
                            mc     <= mc_d;
                            chan   <= ch_d;
                            state  <= ST_IDLE;
                        end
                    end else if (idx_q == EW'(ENTRIES - 1)) begin
                        done  <= 1'b1;
                        err   <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        idx_q  <= idx_q + 1'b1;
                        prev_q <= {1'b0, lim} + 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/ilv_addr_decoder_chk.sv
module ilv_addr_decoder_chk #(
    parameter int AW = 46
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic [AW-1:0] req_addr,
    input logic          busy,
    input logic [AW-1:0] addr_q,
    input logic [AW-1:0] lo_lim,
    input logic [AW-1:0] hi_lim,
    input logic          done,
    input logic          err
);
    localparam logic [AW:0] FOUR_G = (AW+1)'(1) << 32;

    a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r10_err_with_done: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    a_r10_done_has_cause: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy || start));

    a_r1_reject_high: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && (req_addr >= hi_lim)) |=> (done && err));

    a_r1_reject_hole: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && (req_addr >= lo_lim) && ({1'b0, req_addr} < FOUR_G))
        |=> (done && err));

    a_r11_busy_holds_addr: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(addr_q));

endmodule

bind ilv_addr_decoder ilv_addr_decoder_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .start(start), .req_addr(req_addr),
    .busy(busy), .addr_q(addr_q), .lo_lim(lo_lim), .hi_lim(hi_lim),
    .done(done), .err(err)
);

// File: tb/sim_ilv_addr_decoder.sv
module sim_ilv_addr_decoder;
    localparam int NODES   = 4;
    localparam int ENTRIES = 24;
    localparam int AW      = 40;
    localparam int NW      = 2;
    localparam int EW      = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_kind = '0;
    logic [NW-1:0] cfg_node = '0;
    logic [EW-1:0] cfg_idx = '0;
    logic [AW-1:0] cfg_data = '0;
    logic          start = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          done, err;
    logic [2:0]    socket, mc;
    logic [1:0]    chan;

    int nchk = 0;
    int nerr = 0;

    logic [31:0] b_ent   [NODES][ENTRIES];
    logic [31:0] b_ilv   [NODES][ENTRIES];
    logic [33:0] b_route [NODES];
    logic [2:0]  b_src   [NODES];
    logic [63:0] b_lo, b_hi;

    always #4 clk = ~clk;

    ilv_addr_decoder #(.NODES(NODES), .ENTRIES(ENTRIES), .AW(AW)) u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_node(cfg_node), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .start(start), .req_addr(req_addr), .done(done), .err(err),
        .socket(socket), .mc(mc), .chan(chan)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_ent(int en, int mode, int sel, int lim,
                                           int m3, int m3m);
        logic [31:0] w;
        w = '0;
        w[0]     = en[0];
        w[2:1]   = mode[1:0];
        w[6:5]   = sel[1:0];
        w[26:7]  = lim[19:0];
        w[27]    = m3[0];
        w[31:30] = m3m[1:0];
        return w;
    endfunction

    task automatic cfg_wr(input int kind, input int node, input int idx,
                          input logic [63:0] data);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_kind = kind[2:0];
        cfg_node = node[NW-1:0];
        cfg_idx  = idx[EW-1:0];
        cfg_data = data[AW-1:0];
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Reference decode built from the requirement text.
    task automatic ref_decode(input logic [63:0] a, output bit e,
                              output logic [2:0] so, output logic [2:0] mcx,
                              output logic [1:0] chx, output int lat);
        int node; bit red; bit hit; int kk; int sh; int nn;
        logic [63:0] prev, lim, s;
        logic [31:0] w;
        logic [2:0] idx, lch;
        logic [3:0] t;
        logic [1:0] base;
        e = 1'b1; so = '0; mcx = '0; chx = '0; lat = 0;
        node = 0; red = 1'b0; w = '0; kk = 0;
        if (a >= b_hi || (a >= b_lo && a < 64'h1_0000_0000)) return;
        for (int pass = 0; pass < 2; pass++) begin
            hit = 1'b0;
            prev = '0;
            for (int k = 0; k < ENTRIES && !hit; k++) begin
                w = b_ent[node][k];
                lim = ({44'b0, w[26:7]} << 26) | 64'h3FF_FFFF;
                lat++;
                if (w[0] && a >= prev && a <= lim) begin
                    hit = 1'b1;
                    kk = k;
                end else begin
                    prev = lim + 1;
                end
            end
            if (!hit) return;
            case (w[2:1])
                2'd0:    idx = a[8:6];
                2'd1:    idx = a[10:8];
                2'd2:    idx = a[14:12];
                default: idx = a[32:30];
            endcase
            t = b_ilv[node][kk][idx*4 +: 4];
            if (!t[3]) begin
                if (red) return;
                nn = -1;
                for (int n = NODES - 1; n >= 0; n--)
                    if (b_src[n] == t[2:0]) nn = n;
                if (nn < 0) return;
                node = nn;
                red = 1'b1;
                continue;
            end
            if (!w[27]) begin
                lch = t[2:0];
            end else begin
                case (w[31:30])
                    2'd0:    sh = 6;
                    2'd1:    sh = 8;
                    2'd2:    sh = 12;
                    default: return;
                endcase
                s = a >> sh;
                case (w[6:5])
                    2'd0:    base = 2'(s % 3);
                    2'd1:    base = {1'b0, s[0]};
                    2'd2:    base = {s[0], ~s[0]};
                    default: base = {s[0], 1'b0};
                endcase
                lch = {base, t[0]};
            end
            e   = 1'b0;
            so  = b_src[node];
            mcx = b_route[node][3*lch +: 3];
            chx = b_route[node][18 + 2*lch +: 2];
            return;
        end
    endtask

    task automatic run_req(input logic [63:0] a, input bit noisy, input string tag);
        bit e; logic [2:0] so, mcx; logic [1:0] chx; int lat; int cnt;
        ref_decode(a, e, so, mcx, chx, lat);
        @(negedge clk);
        start    = 1'b1;
        req_addr = a[AW-1:0];
        @(posedge clk);
        #1;
        if (noisy) req_addr = 40'h0_9000_0000;
        else start = 1'b0;
        cnt = 0;
        while (!done && cnt < 200) begin
            @(posedge clk);
            #1;
            cnt++;
        end
        start = 1'b0;
        chk(err == e, tag, "err", err, e);
        if (!e) begin
            chk(socket == so, tag, "socket (R9)", socket, so);
            chk(mc == mcx, tag, "mc (R9)", mc, mcx);
            chk(chan == chx, tag, "chan (R9)", chan, chx);
        end
        chk(cnt == lat, tag, "latency (R10)", cnt, lat);
        @(posedge clk);
        #1;
        chk(done == 1'b0, tag, "done width (R10)", done, 0);
    endtask

    initial begin
        #(8 * 150000);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [63:0] bases [13];
        bases = '{64'h0, 64'h0C00_0000, 64'h1000_0000, 64'h1400_0000,
                  64'h1800_0000, 64'h1C00_0000, 64'h2400_0000, 64'h4000_0000,
                  64'h1_0000_0000, 64'h1_4000_0000, 64'h1_8000_0000,
                  64'h1_C000_0000, 64'h2_0000_0000};

        // table contents
        for (int n = 0; n < NODES; n++) begin
            b_src[n]   = 3'((n + 5) & 7);
            b_route[n] = 34'h2_C6A5_3B17 + 34'(n) * 34'h1_1357_9BDF;
            for (int k = 0; k < ENTRIES; k++) begin
                b_ent[n][k] = '0;
                for (int i = 0; i < 8; i++)
                    b_ilv[n][k][i*4 +: 4] = 4'(8 | ((n == 0) ? ((i*3 + k) & 7) : ((i + n) & 7)));
            end
            if (n > 0) b_ent[n][n] = mk_ent(1, 0, 0, 'hBF, 0, 0);
        end
        b_ent[0][0] = mk_ent(1, 0, 0, 0, 0, 0);
        b_ent[0][1] = mk_ent(0, 0, 0, 2, 0, 0);
        b_ent[0][2] = mk_ent(1, 1, 0, 3, 1, 0);
        b_ent[0][3] = mk_ent(1, 2, 1, 4, 1, 1);
        b_ent[0][4] = mk_ent(1, 0, 2, 5, 1, 2);
        b_ent[0][5] = mk_ent(1, 0, 3, 6, 1, 0);
        b_ent[0][6] = mk_ent(1, 0, 0, 7, 1, 3);
        b_ent[0][7] = mk_ent(1, 1, 0, 8, 0, 0);
        b_ent[0][8] = mk_ent(1, 3, 0, 'hBF, 0, 0);
        for (int i = 0; i < 8; i++) b_ilv[0][7][i*4 +: 4] = 4'(i);
        b_lo = 64'h8000_0000;
        b_hi = 64'h10_0000_0000;

        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        #1;
        chk(done == 0 && err == 0, "R12", "reset done/err", {done, err}, 0);
        chk(socket == 0 && mc == 0 && chan == 0, "R12", "reset fields",
            {socket, mc, chan}, 0);

        for (int n = 0; n < NODES; n++) begin
            for (int k = 0; k < ENTRIES; k++) begin
                cfg_wr(0, n, k, {32'b0, b_ent[n][k]});
                cfg_wr(1, n, k, {32'b0, b_ilv[n][k]});
            end
            cfg_wr(2, n, 0, {30'b0, b_route[n]});
            cfg_wr(3, n, 0, {61'b0, b_src[n]});
        end
        cfg_wr(4, 0, 0, b_lo);
        cfg_wr(5, 0, 0, b_hi);

        // R2 R3 R4 R7 R8 R9: sweep of each range of node 0
        for (int r = 0; r < 13; r++)
            for (int j = 0; j < 16; j++)
                run_req(bases[r] + 64'(j) * 64'h1C0 + 64'(j % 3) * 64'h1000
                        + 64'(j >> 2) * 64'h4_0000, 1'b0, "R2 R4 R7 R8 sweep");

        // R5 R6: remote targets, every index of the redirecting range
        for (int i = 0; i < 8; i++)
            run_req(64'h2000_0000 + (64'(i) << 8), 1'b0, "R5 R6 remote");
        for (int j = 0; j < 8; j++)
            run_req(64'h2000_0000 + 64'(j) * 64'h1C0 + 64'h3_0000, 1'b0, "R6 sweep");

        // R3: disabled span still advances the bound; no match at all
        run_req(64'h0500_0000, 1'b0, "R3 disabled span");
        run_req(64'h3_0000_0000, 1'b0, "R3 no match");
        run_req(64'h0BFF_FFFF, 1'b0, "R3 bound edge");
        run_req(64'h03FF_FFFF, 1'b0, "R3 limit edge");

        // R1: hole and high limit boundaries
        run_req(64'h8000_0000, 1'b0, "R1 low edge");
        run_req(64'hFFFF_FFFF, 1'b0, "R1 below 4G");
        run_req(64'h7FFF_FFFF, 1'b0, "R1 under low");
        run_req(64'h10_0000_0000, 1'b0, "R1 at high");
        run_req(64'hF_FFFF_FFFF, 1'b0, "R1 under high");

        // R11: start held with a rejected address during the scan
        run_req(64'h1800_0140, 1'b1, "R11 busy start");
        run_req(64'h2000_0600, 1'b1, "R11 busy remote");
        run_req(64'h1_C000_0040, 1'b1, "R11 busy mode3");

        // R12: rewritten limit and source id take effect
        b_lo = 64'h2000_0000;
        cfg_wr(4, 0, 0, b_lo);
        run_req(64'h2400_0000, 1'b0, "R12 new low");
        b_src[1] = 3'd2;
        cfg_wr(3, 1, 0, 64'd2);
        run_req(64'h1C00_0000 - 64'h100, 1'b0, "R12 src rewrite");
        b_lo = 64'h8000_0000;
        cfg_wr(4, 0, 0, b_lo);
        for (int i = 0; i < 8; i++)
            run_req(64'h2000_0000 + (64'(i) << 8), 1'b0, "R12 R6 after rewrite");

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule